// File: doc/BRIEF.md
# Auxiliary Memory Block Mover

This block copies data between main memory and a secondary audio memory. Software sets up a 16-bit register window with the main-side address, the auxiliary-side address, a byte count and a direction flag. The transfer starts when the low half of the count is written. The engine then runs a sequence of 64-bit beats. Each beat reads one word from the source memory port and writes it to the destination memory port. After each beat, both addresses go up by 8 bytes and the count goes down by 8.

Completion timing is kept apart from the real beat traffic. The busy flag stays high for a delay that grows with the length: 246 cycles for every 32 bytes. Busy never drops before the last beat has finished. When busy drops, a one-cycle completion interrupt is raised. The register window also holds a read-only mode word, which shows the controller as initialised, and a refresh setting.

Top module: `aux_dma`

## Requirements
- R1: After reset, busy and the interrupt are low. The registers read 0, except the mode word, which reads 0x0001, and the refresh word, which reads 156 (0x009C).
- R2: Register indices are: 0 main address high, 1 main address low, 2 auxiliary address high, 3 auxiliary address low, 4 count high, 5 count low, 6 mode, 7 refresh. High halves keep only bits 9:0, which are address or count bits 25:16. Low halves keep only bits 15:5. Count high also keeps bit 15 as the direction flag.
- R3: Writes to the mode word have no effect, and it always reads 0x0001. The refresh word keeps only bits 10:0 of a write.
- R4: A write to count low while idle merges the masked value into the count, starts a transfer and raises busy from the next cycle.
- R5: With direction 0, each beat reads the main port and writes the same 64-bit word to the auxiliary port. With direction 1, data flows from the auxiliary port to the main port.
- R6: A transfer issues count/8 destination writes. Each beat advances both addresses by 8 and lowers the count by 8. Readback returns these live values, so after completion the count reads 0 and each address reads start plus count.
- R7: Both addresses are 26 bits wide and wrap from 0x3FFFFF8 to 0. The memory space therefore mirrors every 64 MB.
- R8: Busy stays high for (count/32)*246 cycles, with a minimum of 1 cycle for a zero count. The interrupt is high for exactly the one cycle in which busy has just fallen.
- R9: While busy, every register write is ignored, including a write to count low. Such a write neither restarts nor lengthens the transfer.
- R10: If the auxiliary address is 16 MB (0x1000000) or above, no beats are issued. The full completion delay and the interrupt still happen.
- R11: Only one memory port requests at a time. A request holds its address and write data stable until acknowledged, and requests appear only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register readback for reg_addr |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| main_req | output | 1 | Main memory request |
| main_we | output | 1 | Main memory write (1) or read (0) |
| main_addr | output | 26 | Main memory byte address |
| main_wdata | output | 64 | Main memory write data |
| main_rdata | input | 64 | Main memory read data, valid with ack |
| main_ack | input | 1 | Main memory acknowledge |
| aux_req | output | 1 | Auxiliary memory request |
| aux_we | output | 1 | Auxiliary memory write (1) or read (0) |
| aux_addr | output | 26 | Auxiliary memory byte address |
| aux_wdata | output | 64 | Auxiliary memory write data |
| aux_rdata | input | 64 | Auxiliary memory read data, valid with ack |
| aux_ack | input | 1 | Auxiliary memory acknowledge |

## Verification
The transfer path runs with several setups:
- One-chunk, two-chunk and three-chunk lengths. These separate a correct delay multiplier from an off-by-one or a fixed delay.
- Both directions. This catches a swapped source or destination.
- A main address just below the 64 MB top. This shows whether the addresses wrap or carry.

Further directed cases cover the rest of the behaviour:
- Over-wide writes, which expose each register mask.
- A zero count, which shows the minimum busy time.
- An out-of-range auxiliary address, which must produce no traffic but still take the full delay.
- Writes issued during a running transfer, which must not restart it.

// File: rtl/aux_dma_pkg.sv
// Shared types for the auxiliary memory block mover.
// Assumes a 3-bit register index; the index values are software-visible.
package aux_dma_pkg;

    typedef enum logic [2:0] {
        REG_MAIN_HI = 3'd0,
        REG_MAIN_LO = 3'd1,
        REG_AUX_HI  = 3'd2,
        REG_AUX_LO  = 3'd3,
        REG_CNT_HI  = 3'd4,
        REG_CNT_LO  = 3'd5,
        REG_MODE    = 3'd6,
        REG_REFRESH = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2
    } mover_state_e;

    typedef struct packed {
        logic main_hi;
        logic main_lo;
        logic aux_hi;
        logic aux_lo;
        logic cnt_hi;
    } cfg_wr_t;

endpackage

// File: rtl/aux_dma_regif.sv
// Register window: decodes 16-bit writes into masked field updates,
// raises the start pulse, holds the refresh word and muxes readback.
// Assumes ADDR_W is between 17 and 31. All writes are dropped while busy.
module aux_dma_regif
    import aux_dma_pkg::*;
#(
    parameter int          ADDR_W        = 26,
    parameter int          ALIGN_BITS    = 5,
    parameter logic [15:0] REFRESH_RESET = 16'd156,
    parameter logic [15:0] REFRESH_MASK  = 16'h07FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic              busy,
    input  logic [ADDR_W-1:0] main_q,
    input  logic [ADDR_W-1:0] aux_q,
    input  logic [ADDR_W-1:0] count_q,
    input  logic              dir_q,
    output cfg_wr_t           cfg_wr,
    output logic [ADDR_W-17:0] hi_data,
    output logic [15:0]       lo_data,
    output logic              dir_data,
    output logic              start,
    output logic [ADDR_W-1:0] start_count,
    output logic [15:0]       reg_rdata
);
    localparam int HI_W = ADDR_W - 16;

    logic       accept;
    reg_sel_e   sel;
    logic [15:0] refresh_q;

    assign sel    = reg_sel_e'(reg_addr);
    assign accept = reg_wr && !busy;

    // Masked write data shared by all fields.
    always_comb begin
        hi_data     = reg_wdata[HI_W-1:0];
        lo_data     = {reg_wdata[15:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        dir_data    = reg_wdata[15];
        start_count = {count_q[ADDR_W-1:16], lo_data};
    end

    // Field write strobes and the start pulse.
    always_comb begin
        cfg_wr         = '0;
        cfg_wr.main_hi = accept && (sel == REG_MAIN_HI);
        cfg_wr.main_lo = accept && (sel == REG_MAIN_LO);
        cfg_wr.aux_hi  = accept && (sel == REG_AUX_HI);
        cfg_wr.aux_lo  = accept && (sel == REG_AUX_LO);
        cfg_wr.cnt_hi  = accept && (sel == REG_CNT_HI);
        start          = accept && (sel == REG_CNT_LO);
    end

    // Refresh setting register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            refresh_q <= REFRESH_RESET;
        else if (accept && sel == REG_REFRESH)
            refresh_q <= reg_wdata & REFRESH_MASK;
    end

    // Readback of live values.
    always_comb begin
        case (sel)
            REG_MAIN_HI: reg_rdata = {{(16-HI_W){1'b0}}, main_q[ADDR_W-1:16]};
            REG_MAIN_LO: reg_rdata = main_q[15:0];
            REG_AUX_HI:  reg_rdata = {{(16-HI_W){1'b0}}, aux_q[ADDR_W-1:16]};
            REG_AUX_LO:  reg_rdata = aux_q[15:0];
            REG_CNT_HI:  reg_rdata = {dir_q, {(15-HI_W){1'b0}}, count_q[ADDR_W-1:16]};
            REG_CNT_LO:  reg_rdata = count_q[15:0];
            REG_MODE:    reg_rdata = 16'h0001;
            default:     reg_rdata = refresh_q;
        endcase
    end

    assert_refresh_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_REFRESH) |-> ((reg_rdata & ~REFRESH_MASK) == 16'h0));

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && busy) |=> $stable(refresh_q));

endmodule

// File: rtl/aux_dma_mover.sv
// Beat engine: holds both addresses, the count and the direction, and
// moves one DATA_W word per beat (read source, then write destination).
// Assumes config strobes never arrive while a transfer is active.
module aux_dma_mover
    import aux_dma_pkg::*;
#(
    parameter int          ADDR_W   = 26,
    parameter int          DATA_W   = 64,
    parameter int unsigned AUX_SIZE = 32'h0100_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_wr_t            cfg_wr,
    input  logic [ADDR_W-17:0] hi_data,
    input  logic [15:0]        lo_data,
    input  logic               dir_data,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_count,
    output logic [ADDR_W-1:0]  main_q,
    output logic [ADDR_W-1:0]  aux_q,
    output logic [ADDR_W-1:0]  count_q,
    output logic               dir_q,
    output logic               active,
    output logic               main_req,
    output logic               main_we,
    output logic [ADDR_W-1:0]  main_addr,
    output logic [DATA_W-1:0]  main_wdata,
    input  logic [DATA_W-1:0]  main_rdata,
    input  logic               main_ack,
    output logic               aux_req,
    output logic               aux_we,
    output logic [ADDR_W-1:0]  aux_addr,
    output logic [DATA_W-1:0]  aux_wdata,
    input  logic [DATA_W-1:0]  aux_rdata,
    input  logic               aux_ack
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(BEAT_BYTES);

    mover_state_e        state;
    logic [DATA_W-1:0]   beat_q;
    logic                in_range;
    logic                src_ack;
    logic                dst_ack;
    logic [DATA_W-1:0]   src_rdata;
    logic                advance;

    assign in_range  = ({{(32-ADDR_W){1'b0}}, aux_q} < AUX_SIZE);
    assign src_ack   = dir_q ? aux_ack : main_ack;
    assign dst_ack   = dir_q ? main_ack : aux_ack;
    assign src_rdata = dir_q ? aux_rdata : main_rdata;
    assign advance   = (state == MV_WRITE) && dst_ack;
    assign active    = (state != MV_IDLE);

    // Port drive: the read phase uses the source, the write phase the destination.
    always_comb begin
        main_req   = ((state == MV_READ) && !dir_q) || ((state == MV_WRITE) && dir_q);
        aux_req    = ((state == MV_READ) && dir_q) || ((state == MV_WRITE) && !dir_q);
        main_we    = (state == MV_WRITE);
        aux_we     = (state == MV_WRITE);
        main_addr  = main_q;
        aux_addr   = aux_q;
        main_wdata = beat_q;
        aux_wdata  = beat_q;
    end

    // Beat sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MV_IDLE;
        end else begin
            case (state)
                MV_IDLE:  if (start && start_count != '0 && in_range) state <= MV_READ;
                MV_READ:  if (src_ack) state <= MV_WRITE;
                MV_WRITE: if (dst_ack) state <= (count_q == BEAT_STEP) ? MV_IDLE : MV_READ;
                default:  state <= MV_IDLE;
            endcase
        end
    end

    // Capture the word read from the source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_q <= '0;
        else if (state == MV_READ && src_ack)
            beat_q <= src_rdata;
    end

    // Address, count and direction: config updates, start load, per-beat advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q  <= '0;
            aux_q   <= '0;
            count_q <= '0;
            dir_q   <= 1'b0;
        end else begin
            if (cfg_wr.main_hi) main_q[ADDR_W-1:16]  <= hi_data;
            if (cfg_wr.main_lo) main_q[15:0]         <= lo_data;
            if (cfg_wr.aux_hi)  aux_q[ADDR_W-1:16]   <= hi_data;
            if (cfg_wr.aux_lo)  aux_q[15:0]          <= lo_data;
            if (cfg_wr.cnt_hi) begin
                count_q[ADDR_W-1:16] <= hi_data;
                dir_q                <= dir_data;
            end
            if (start) count_q <= start_count;
            if (advance) begin
                main_q  <= main_q + BEAT_STEP;
                aux_q   <= aux_q + BEAT_STEP;
                count_q <= count_q - BEAT_STEP;
            end
        end
    end

    assert_single_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_req, aux_req}));

    assert_main_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (main_req && !main_ack) |=> ($stable(main_addr) && $stable(main_wdata)));

    assert_aux_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_req && !aux_ack) |=> ($stable(aux_addr) && $stable(aux_wdata)));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (count_q == $past(count_q) - BEAT_STEP));

endmodule

// File: rtl/aux_dma_ctl.sv
// Completion control: owns busy, runs the length-proportional delay
// counter and emits the one-cycle completion pulse.
// Assumes the start pulse only arrives while idle.
module aux_dma_ctl #(
    parameter int ADDR_W           = 26,
    parameter int CHUNK_SHIFT      = 5,
    parameter int CYCLES_PER_CHUNK = 246
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [ADDR_W-CHUNK_SHIFT-1:0] start_chunks,
    input  logic                          mover_active,
    output logic                          busy,
    output logic                          done_irq
);
    localparam int TMR_W = ADDR_W - CHUNK_SHIFT + $clog2(CYCLES_PER_CHUNK + 1);

    logic [TMR_W-1:0] timer_q;
    logic [TMR_W-1:0] delay;

    assign delay = TMR_W'(start_chunks) * TMR_W'(CYCLES_PER_CHUNK);

    // Busy, delay countdown and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            timer_q  <= '0;
            done_irq <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                timer_q <= delay;
            end else if (busy) begin
                if (timer_q != '0) timer_q <= timer_q - 1'b1;
                if (timer_q <= TMR_W'(1) && !mover_active) begin
                    busy     <= 1'b0;
                    done_irq <= 1'b1;
                end
            end
        end
    end

    assert_irq_on_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!busy && $past(busy)));

    assert_beats_inside_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mover_active |-> busy);

endmodule

// File: rtl/aux_dma.sv
// Top of the auxiliary memory block mover: register window, beat engine
// and completion control. Memory ports follow a request/acknowledge
// handshake; read data is valid in the acknowledge cycle.
module aux_dma
    import aux_dma_pkg::*;
#(
    parameter int          ADDR_W           = 26,
    parameter int          DATA_W           = 64,
    parameter int unsigned AUX_SIZE         = 32'h0100_0000,
    parameter int          CYCLES_PER_CHUNK = 246,
    parameter logic [15:0] REFRESH_RESET    = 16'd156
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              busy,
    output logic              done_irq,
    output logic              main_req,
    output logic              main_we,
    output logic [ADDR_W-1:0] main_addr,
    output logic [DATA_W-1:0] main_wdata,
    input  logic [DATA_W-1:0] main_rdata,
    input  logic              main_ack,
    output logic              aux_req,
    output logic              aux_we,
    output logic [ADDR_W-1:0] aux_addr,
    output logic [DATA_W-1:0] aux_wdata,
    input  logic [DATA_W-1:0] aux_rdata,
    input  logic              aux_ack
);
    localparam int CHUNK_SHIFT = 5;

    cfg_wr_t             cfg_wr;
    logic [ADDR_W-17:0]  hi_data;
    logic [15:0]         lo_data;
    logic                dir_data;
    logic                start;
    logic [ADDR_W-1:0]   start_count;
    logic [ADDR_W-1:0]   main_q;
    logic [ADDR_W-1:0]   aux_q;
    logic [ADDR_W-1:0]   count_q;
    logic                dir_q;
    logic                mover_active;

    aux_dma_regif #(
        .ADDR_W        (ADDR_W),
        .ALIGN_BITS    (CHUNK_SHIFT),
        .REFRESH_RESET (REFRESH_RESET),
        .REFRESH_MASK  (16'h07FF)
    ) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .busy        (busy),
        .main_q      (main_q),
        .aux_q       (aux_q),
        .count_q     (count_q),
        .dir_q       (dir_q),
        .cfg_wr      (cfg_wr),
        .hi_data     (hi_data),
        .lo_data     (lo_data),
        .dir_data    (dir_data),
        .start       (start),
        .start_count (start_count),
        .reg_rdata   (reg_rdata)
    );

    aux_dma_mover #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .AUX_SIZE (AUX_SIZE)
    ) u_mover (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .hi_data     (hi_data),
        .lo_data     (lo_data),
        .dir_data    (dir_data),
        .start       (start),
        .start_count (start_count),
        .main_q      (main_q),
        .aux_q       (aux_q),
        .count_q     (count_q),
        .dir_q       (dir_q),
        .active      (mover_active),
        .main_req    (main_req),
        .main_we     (main_we),
        .main_addr   (main_addr),
        .main_wdata  (main_wdata),
        .main_rdata  (main_rdata),
        .main_ack    (main_ack),
        .aux_req     (aux_req),
        .aux_we      (aux_we),
        .aux_addr    (aux_addr),
        .aux_wdata   (aux_wdata),
        .aux_rdata   (aux_rdata),
        .aux_ack     (aux_ack)
    );

    aux_dma_ctl #(
        .ADDR_W           (ADDR_W),
        .CHUNK_SHIFT      (CHUNK_SHIFT),
        .CYCLES_PER_CHUNK (CYCLES_PER_CHUNK)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_chunks (start_count[ADDR_W-1:CHUNK_SHIFT]),
        .mover_active (mover_active),
        .busy         (busy),
        .done_irq     (done_irq)
    );

    assert_req_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (main_req || aux_req) |-> busy);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(count_q) || $past(main_ack) || $past(aux_ack));

endmodule

// File: tb/aux_dma_tb.sv
`timescale 1ns/1ps
module aux_dma_tb;

    localparam int AW  = 26;
    localparam int DW  = 64;
    localparam int CPC = 246;

    typedef struct packed {
        logic [AW-1:0] m;
        logic [AW-1:0] a;
        logic [AW-1:0] c;
        logic          dir;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{26'h0000100, 26'h0000200, 26'h0000040, 1'b0},
        '{26'h0000400, 26'h0000080, 26'h0000020, 1'b1},
        '{26'h0A00040, 26'h0000300, 26'h0000060, 1'b0},
        '{26'h0000600, 26'h0FFFFE0, 26'h0000020, 1'b1},
        '{26'h3FFFFE0, 26'h0000800, 26'h0000040, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [15:0]   reg_wdata = 16'd0;
    logic [15:0]   reg_rdata;
    logic          busy, done_irq;
    logic          main_req, main_we, main_ack;
    logic [AW-1:0] main_addr;
    logic [DW-1:0] main_wdata, main_rdata;
    logic          aux_req, aux_we, aux_ack;
    logic [AW-1:0] aux_addr;
    logic [DW-1:0] aux_wdata, aux_rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int t0 = 0;
    int main_rd_n, main_wr_n, aux_rd_n, aux_wr_n, both_req_n;
    bit finished = 0;

    logic [DW-1:0] main_mem [0:1023];
    logic [DW-1:0] aux_mem  [0:1023];
    logic [DW-1:0] snap     [0:15];

    always #4 clk = ~clk;

    aux_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done_irq(done_irq),
        .main_req(main_req), .main_we(main_we), .main_addr(main_addr),
        .main_wdata(main_wdata), .main_rdata(main_rdata), .main_ack(main_ack),
        .aux_req(aux_req), .aux_we(aux_we), .aux_addr(aux_addr),
        .aux_wdata(aux_wdata), .aux_rdata(aux_rdata), .aux_ack(aux_ack)
    );

    // Memory stubs: acknowledge one cycle after a request, count accesses.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            main_ack <= 1'b0; aux_ack <= 1'b0;
            main_rdata <= '0; aux_rdata <= '0;
            main_rd_n <= 0; main_wr_n <= 0; aux_rd_n <= 0; aux_wr_n <= 0; both_req_n <= 0;
            for (int i = 0; i < 1024; i++) begin
                main_mem[i] <= 64'hA500_0000_0000_0000 | 64'(i * 3 + 1);
                aux_mem[i]  <= 64'h5A00_0000_0000_0000 | 64'(i * 7 + 2);
            end
        end else begin
            main_ack <= main_req && !main_ack;
            aux_ack  <= aux_req && !aux_ack;
            if (main_req && aux_req) both_req_n <= both_req_n + 1;
            if (main_req && !main_ack) begin
                if (main_we) begin
                    main_mem[main_addr[12:3]] <= main_wdata;
                    main_wr_n <= main_wr_n + 1;
                end else begin
                    main_rdata <= main_mem[main_addr[12:3]];
                    main_rd_n <= main_rd_n + 1;
                end
            end
            if (aux_req && !aux_ack) begin
                if (aux_we) begin
                    aux_mem[aux_addr[12:3]] <= aux_wdata;
                    aux_wr_n <= aux_wr_n + 1;
                end else begin
                    aux_rdata <= aux_mem[aux_addr[12:3]];
                    aux_rd_n <= aux_rd_n + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Start a transfer by writing count low; checks busy rises (R4).
    task automatic kick(input logic [15:0] lo);
        wr(3'd5, lo);
        t0 = cyc;
        chk("R4 busy after start", busy, 1'b1);
    endtask

    // Wait for busy to fall, check duration and the interrupt pulse (R8).
    task automatic finish_xfer(input int exp_dur);
        while (busy && (cyc - t0) < 100000) @(negedge clk);
        chk("R8 busy duration", 64'(cyc - t0), 64'(exp_dur));
        chk("R8 irq with busy fall", done_irq, 1'b1);
        @(negedge clk);
        chk("R8 irq one cycle", done_irq, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [AW-1:0] src, dst;
        int mw, aw, mr, ar, beats;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", busy, 1'b0);
        chk("R1 irq", done_irq, 1'b0);
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), r);
            chk("R1 reg zero", r, 16'h0000);
        end
        rd(3'd6, r); chk("R1 mode", r, 16'h0001);
        rd(3'd7, r); chk("R1 refresh", r, 16'h009C);

        // Table of transfers: R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, {6'b0, VECS[v].m[25:16]});
            wr(3'd1, VECS[v].m[15:0]);
            wr(3'd2, {6'b0, VECS[v].a[25:16]});
            wr(3'd3, VECS[v].a[15:0]);
            wr(3'd4, {VECS[v].dir, 5'b0, VECS[v].c[25:16]});
            beats = int'(VECS[v].c) / 8;
            src = VECS[v].dir ? VECS[v].a : VECS[v].m;
            dst = VECS[v].dir ? VECS[v].m : VECS[v].a;
            for (int k = 0; k < beats; k++) begin
                logic [AW-1:0] sa;
                sa = src + AW'(8 * k);
                snap[k] = VECS[v].dir ? aux_mem[sa[12:3]] : main_mem[sa[12:3]];
            end
            mw = main_wr_n; aw = aux_wr_n;
            kick(VECS[v].c[15:0]);
            finish_xfer((int'(VECS[v].c) / 32) * CPC);
            for (int k = 0; k < beats; k++) begin
                logic [AW-1:0] da;
                da = dst + AW'(8 * k);
                chk("R5 R7 beat data",
                    VECS[v].dir ? main_mem[da[12:3]] : aux_mem[da[12:3]], snap[k]);
            end
            chk("R6 beat count", VECS[v].dir ? 64'(main_wr_n - mw) : 64'(aux_wr_n - aw),
                64'(beats));
            rd(3'd5, r); chk("R6 count low live", r, 16'h0000);
            rd(3'd1, r); chk("R6 R7 main low live", r, 16'(VECS[v].m + VECS[v].c));
            rd(3'd0, r); chk("R7 main high live", r, {6'b0, 10'((VECS[v].m + VECS[v].c) >> 16)});
            rd(3'd3, r); chk("R6 aux low live", r, 16'(VECS[v].a + VECS[v].c));
        end

        // R2: write masks
        wr(3'd0, 16'hFFFF); rd(3'd0, r); chk("R2 main hi mask", r, 16'h03FF);
        wr(3'd1, 16'hFFFF); rd(3'd1, r); chk("R2 main lo mask", r, 16'hFFE0);
        wr(3'd3, 16'hFFFF); rd(3'd3, r); chk("R2 aux lo mask", r, 16'hFFE0);
        wr(3'd4, 16'hFFFF); rd(3'd4, r); chk("R2 count hi mask", r, 16'h83FF);

        // R3: mode read-only, refresh mask
        wr(3'd6, 16'hFFFF); rd(3'd6, r); chk("R3 mode read-only", r, 16'h0001);
        wr(3'd7, 16'hFFFF); rd(3'd7, r); chk("R3 refresh mask", r, 16'h07FF);

        // R10 with R2 count-low mask: aux at 16 MB, no beats, full delay
        wr(3'd2, 16'h0100);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0000);
        mw = main_wr_n; aw = aux_wr_n; mr = main_rd_n; ar = aux_rd_n;
        kick(16'h003F);
        finish_xfer(CPC);
        chk("R10 no traffic",
            64'((main_wr_n - mw) + (aux_wr_n - aw) + (main_rd_n - mr) + (aux_rd_n - ar)), 64'd0);
        rd(3'd5, r); chk("R10 R2 count lo kept", r, 16'h0020);

        // R8: zero count still completes after one cycle
        wr(3'd5, 16'h0000);
        t0 = cyc - 1;
        t0 = t0 + 1;
        finish_xfer(1);

        // R9: writes during a transfer are ignored
        wr(3'd0, 16'h0000); wr(3'd1, 16'h0100);
        wr(3'd2, 16'h0000); wr(3'd3, 16'h0900);
        wr(3'd4, 16'h0000);
        kick(16'h0020);
        wr(3'd1, 16'hFFE0);
        wr(3'd5, 16'h0FE0);
        wr(3'd7, 16'h0001);
        finish_xfer(CPC);
        rd(3'd1, r); chk("R9 main lo not rewritten", r, 16'h0120);
        rd(3'd5, r); chk("R9 no restart", r, 16'h0000);
        rd(3'd7, r); chk("R9 refresh kept", r, 16'h07FF);

        // R11: ports never requested together
        chk("R11 single port", 64'(both_req_n), 64'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // R11: bench-side check that an open request keeps its address
    logic          prev_open;
    logic [AW-1:0] prev_addr;
    always @(posedge clk) begin
        if (!rst_n) begin
            prev_open <= 1'b0;
            prev_addr <= '0;
        end else begin
            if (prev_open && main_addr !== prev_addr) begin
                total++; bad++;
                $display("FAIL R11 main address moved actual=%0h expected=%0h", main_addr, prev_addr);
            end
            prev_open <= main_req && !main_ack;
            prev_addr <= main_addr;
        end
    end

endmodule